// File: doc/BRIEF.md
# Selectable-Ratio Clock Divider with Four-Pair Fanout

This block sits behind a frequency synthesizer's oscillator and turns its high-speed clock into four complementary clock pairs. A ratio select picks division by two or by four, and both ratios produce a square wave with equal high and low times. The new ratio is only adopted when the current output period has finished, so a change never produces a shortened pulse.

For bring-up, a bypass select feeds a reference clock to the divider instead of the oscillator clock. A second select picks that reference from either a crystal-derived clock or a test clock. The reference is synchronised into the oscillator clock domain, and each of its rising edges advances the divider by one step. The reference therefore has to run well below the oscillator clock.

An active-high master reset drives every true output low and every complement output high. The outputs change as soon as the reset is raised. The divider stays parked while the reset is high and restarts cleanly when it falls. The ratio select is not touched by the reset. A separate active-low power-on reset initialises the block; it asserts asynchronously and releases synchronously.

Top module: `clkdiv_fanout`

## Requirements
- R1: With `bypass`=0 and `n_sel`=0, each `q_p` bit is high for 1 `vco_clk` cycle and then low for 1 cycle, repeating.
- R2: With `bypass`=0 and `n_sel`=1, each `q_p` bit is high for 2 `vco_clk` cycles and then low for 2 cycles, repeating.
- R3: A change of `n_sel` takes effect only at the next rising edge of the output. The period under way finishes at the old ratio, and no high or low time shorter than that ratio's half-period appears.
- R4: While `mr`=1, `q_p` is all zeros and `q_n` is all ones. This holds from the first sample after `mr` rises and for as long as `mr` stays high.
- R5: After `mr` falls, the divider restarts with a rising output edge. It then runs at the ratio still selected by `n_sel`.
- R6: With `bypass`=1 and `ref_sel`=1, the divider steps once per rising edge of `xtal_clk`. Each high time and each low time lasts one reference period for `n_sel`=0 and two reference periods for `n_sel`=1.
- R7: With `bypass`=1 and `ref_sel`=0, `test_clk` is used in place of `xtal_clk`, with the same stepping rule.
- R8: All four `q_p` bits carry the same waveform, and each `q_n` bit is the inverse of its `q_p` bit on every sample.
- R9: While `rst_n`=0, `q_p` is all zeros and `q_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | High-speed oscillator clock; also the clock of all internal logic |
| rst_n | input | 1 | Power-on reset, active low, asserts asynchronously, releases synchronously |
| xtal_clk | input | 1 | Crystal-derived reference clock |
| test_clk | input | 1 | Test reference clock |
| ref_sel | input | 1 | 1 selects xtal_clk, 0 selects test_clk as the reference |
| bypass | input | 1 | 1 drives the divider from the reference, 0 from vco_clk |
| n_sel | input | 1 | Ratio select: 0 divides by 2, 1 divides by 4 |
| mr | input | 1 | Master reset, active high; forces the outputs and parks the divider |
| q_p | output | 4 | True clock outputs |
| q_n | output | 4 | Complement clock outputs |

## Verification
The embedded assertions check the stepping rules of the divider on every cycle. At a ratio of two, every step flips the output. At a ratio of four, only odd phases flip it. The ratio register may change only on a wrap to phase zero with a rising output. The divider output is low whenever the synchronised master reset is high, and a bypass step never lasts two cycles in a row. The bench's scenarios are needed for the end-to-end effects. These are the measured high and low times for each source and ratio, the choice between the crystal and test references, and the alignment of a ratio change to a live output edge. They also cover the immediate forcing of the pins by the master reset and the restart once it falls.

// File: rtl/clkdiv_fanout_pkg.sv
package clkdiv_fanout_pkg;

  typedef enum logic {
    RATIO_DIV2 = 1'b0,
    RATIO_DIV4 = 1'b1
  } ratio_e;

  // phase counter covers the longest period (four steps)
  localparam int unsigned PHASE_W = 2;

endpackage

// File: rtl/cdf_bit_sync.sv
module cdf_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdf_step_gen.sv
module cdf_step_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_clk,
  input  logic test_clk,
  input  logic ref_sel,
  input  logic bypass,
  output logic step
);

  logic ref_raw;
  logic ref_sync;
  logic ref_prev_q;
  logic ref_prev_d;
  logic ref_rise;

  always_comb begin
    ref_raw = ref_sel ? xtal_clk : test_clk;
  end

  cdf_bit_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_ref_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ref_raw),
    .q    (ref_sync)
  );

  always_comb begin
    ref_prev_d = ref_sync;
    ref_rise   = ref_sync & ~ref_prev_q;
    step       = bypass ? ref_rise : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
    end else begin
      ref_prev_q <= ref_prev_d;
    end
  end

  // R6 R7: one step per reference rising edge, never on two cycles running
  ref_step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise);

endmodule

// File: rtl/cdf_ratio_div.sv
module cdf_ratio_div
  import clkdiv_fanout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hold,
  input  logic n_sel,
  output logic div_out
);

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [PHASE_W-1:0] phase_inc;
  logic [PHASE_W-1:0] phase_last;
  logic [PHASE_W-1:0] phase_half;
  ratio_e             ratio_q, ratio_d;
  logic               out_q, out_d;

  always_comb begin
    phase_inc  = phase_q + PHASE_W'(1);
    phase_last = (ratio_q == RATIO_DIV4) ? PHASE_W'(3) : PHASE_W'(1);
    phase_half = (ratio_q == RATIO_DIV4) ? PHASE_W'(2) : PHASE_W'(1);
    phase_d    = phase_q;
    ratio_d    = ratio_q;
    out_d      = out_q;
    if (hold) begin
      // park one step before a wrap so the restart begins a fresh period
      phase_d = '1;
      ratio_d = RATIO_DIV4;
      out_d   = 1'b0;
    end else if (step) begin
      if (phase_q == phase_last) begin
        phase_d = '0;
        ratio_d = ratio_e'(n_sel);
        out_d   = 1'b1;
      end else begin
        phase_d = phase_inc;
        out_d   = (phase_inc < phase_half);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '1;
      ratio_q <= RATIO_DIV4;
      out_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ratio_q <= ratio_d;
      out_q   <= out_d;
    end
  end

  assign div_out = out_q;

  // R1
  div2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step && ratio_q == RATIO_DIV2) |=> (out_q != $past(out_q)));

  // R2
  div4_odd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step && ratio_q == RATIO_DIV4 && phase_q[0]) |=> (out_q != $past(out_q)));

  // R2
  div4_even_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step && ratio_q == RATIO_DIV4 && !phase_q[0]) |=> $stable(out_q));

  // R3
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold) && ratio_q != $past(ratio_q)) |-> (phase_q == '0 && out_q));

  // R4
  hold_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !out_q);

endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int unsigned NUM_PAIRS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 vco_clk,
  input  logic                 rst_n,
  input  logic                 xtal_clk,
  input  logic                 test_clk,
  input  logic                 ref_sel,
  input  logic                 bypass,
  input  logic                 n_sel,
  input  logic                 mr,
  output logic [NUM_PAIRS-1:0] q_p,
  output logic [NUM_PAIRS-1:0] q_n
);

  logic rst_sync_n;
  logic mr_sync;
  logic step;
  logic div_out;

  // power-on reset: asynchronous assertion, release aligned to vco_clk
  cdf_bit_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk  (vco_clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_sync_n)
  );

  cdf_bit_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_mr_sync (
    .clk  (vco_clk),
    .rst_n(rst_sync_n),
    .d    (mr),
    .q    (mr_sync)
  );

  cdf_step_gen #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_step (
    .clk     (vco_clk),
    .rst_n   (rst_sync_n),
    .xtal_clk(xtal_clk),
    .test_clk(test_clk),
    .ref_sel (ref_sel),
    .bypass  (bypass),
    .step    (step)
  );

  cdf_ratio_div u_div (
    .clk    (vco_clk),
    .rst_n  (rst_sync_n),
    .step   (step),
    .hold   (mr_sync),
    .n_sel  (n_sel),
    .div_out(div_out)
  );

  // mr gates the pins directly so they are forced before the sync catches up
  for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
    always_comb begin
      q_p[gi] = div_out & ~mr;
      q_n[gi] = ~q_p[gi];
    end
  end

endmodule

// File: tb/clkdiv_fanout_tb.sv
module clkdiv_fanout_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic       vco_clk = 1'b0;
  logic       rst_n, xtal_clk, test_clk, ref_sel, bypass, n_sel, mr;
  logic [3:0] q_p, q_n;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  bit    wd_fired = 0;
  bit    mon_en   = 0;
  bit    prev_q   = 0;
  int    run_len  = 0;
  int    skip_runs = 0;
  int    exp_q[$];
  string cur_tag  = "";

  clkdiv_fanout u_dut (
    .vco_clk (vco_clk),
    .rst_n   (rst_n),
    .xtal_clk(xtal_clk),
    .test_clk(test_clk),
    .ref_sel (ref_sel),
    .bypass  (bypass),
    .n_sel   (n_sel),
    .mr      (mr),
    .q_p     (q_p),
    .q_n     (q_n)
  );

  always #(CLK_PERIOD/2) vco_clk = ~vco_clk;

  // references: edges offset from every vco_clk edge
  initial begin
    xtal_clk = 1'b0;
    #2;
    forever #(3*CLK_PERIOD) xtal_clk = ~xtal_clk;   // period 6 cycles
  end
  initial begin
    test_clk = 1'b0;
    #2;
    forever #(5*CLK_PERIOD) test_clk = ~test_clk;   // period 10 cycles
  end

  task automatic report(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // monitor: pairwise consistency every sample, run lengths against the queue
  always @(negedge vco_clk) begin
    if (mon_en) begin
      report((q_n == ~q_p) && (q_p == {4{q_p[0]}}), "R8",
             "pair mismatch q_p/q_n", int'({q_p, q_n}), int'({{4{q_p[0]}}, ~{4{q_p[0]}}}));
      if (q_p[0] == prev_q) begin
        run_len++;
      end else begin
        if (exp_q.size() > 0) begin
          if (skip_runs > 0) begin
            skip_runs--;
          end else begin
            int e;
            e = exp_q.pop_front();
            report(run_len == e, cur_tag, "run length", run_len, e);
          end
        end
        run_len = 1;
      end
      prev_q = q_p[0];
    end
  end

  always @(posedge vco_clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !wd_fired) begin
      wd_fired = 1;
      report(1'b0, "WATCHDOG", "cycles", cycles, WD_LIMIT);
      finish_run();
    end
  end

  task automatic settle(int n);
    repeat (n) @(posedge vco_clk);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 && !wd_fired) @(negedge vco_clk);
  endtask

  task automatic expect_runs(int len, int cnt, int skip, string tag);
    cur_tag   = tag;
    skip_runs = skip;
    for (int i = 0; i < cnt; i++) exp_q.push_back(len);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; ref_sel = 1'b1; bypass = 1'b0; n_sel = 1'b0; mr = 1'b0;
    repeat (3) @(negedge vco_clk);
    // R9: outputs parked during power-on reset
    report(q_p == 4'h0, "R9", "q_p in reset", int'(q_p), 0);
    report(q_n == 4'hF, "R9", "q_n in reset", int'(q_n), 15);
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R1: divide by two from the oscillator
    settle(20);
    expect_runs(1, 6, 1, "R1");

    // R2: divide by four from the oscillator
    n_sel = 1'b1;
    settle(20);
    expect_runs(2, 6, 1, "R2");

    // R3: /4 -> /2 requested right after a rising edge; old period completes
    @(posedge q_p[0]); #1;
    n_sel = 1'b0; cur_tag = "R3"; skip_runs = 1;
    exp_q.push_back(2); exp_q.push_back(2);
    for (int i = 0; i < 4; i++) exp_q.push_back(1);
    drain();

    // R3: /2 -> /4 requested right after a rising edge
    @(posedge q_p[0]); #1;
    n_sel = 1'b1; cur_tag = "R3"; skip_runs = 1;
    exp_q.push_back(1); exp_q.push_back(1);
    for (int i = 0; i < 4; i++) exp_q.push_back(2);
    drain();

    // R4: master reset forces the pins at once and keeps them there
    settle(3);
    mr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge vco_clk);
      report(q_p == 4'h0, "R4", "q_p under mr", int'(q_p), 0);
      report(q_n == 4'hF, "R4", "q_n under mr", int'(q_n), 15);
    end

    // R5: release restarts at the ratio still selected (/4)
    settle(1);
    cur_tag = "R5"; skip_runs = 1;
    for (int i = 0; i < 4; i++) exp_q.push_back(2);
    mr = 1'b0;
    drain();

    // R6: bypass from the crystal reference (6-cycle period)
    bypass = 1'b1; ref_sel = 1'b1; n_sel = 1'b0;
    settle(60);
    expect_runs(6, 4, 1, "R6");
    n_sel = 1'b1;
    settle(60);
    expect_runs(12, 4, 1, "R6");

    // R7: bypass from the test reference (10-cycle period)
    ref_sel = 1'b0; n_sel = 1'b0;
    settle(60);
    expect_runs(10, 4, 1, "R7");

    settle(5);
    finish_run();
  end

endmodule